// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one capture/compare channel that sits beside an 8-bit timer counter. It does not count. It watches the count, the counting direction, a tick strobe that marks a new count value, and the counter's clear pulse. In compare mode it drives a single output pin. An action code chooses what a match between the count and the channel value does to the pin. Some codes also act when the count passes zero or reaches its top value. In capture mode it synchronizes an external pin, detects the selected edges and copies the current count into the value register.

The value register can be written at any time. In compare mode a write is parked in a holding register and only moves into the live value when the counter ticks at zero, so the compare period never changes mid-cycle. In capture mode a write lands at once. A sticky channel flag is raised by captures and compare matches, and the interrupt output is that flag gated by a mask bit. All pins are plain control and status signals. There is no streaming data path, so no valid/ready handshake exists and no back-pressure applies.

Top module: `tmr_cc_channel`

## Requirements
- R1: After reset: mask = 1, action code = 000, channel mode = capture (0), edge select = 00, value = 0x00, output pin = 0, flag = 0, irq = 0.
- R2: In compare mode (mode bit = 1), on a tick whose count equals the value, action code 000 drives the pin high, 001 drives it low and 010 inverts it.
- R3: Code 011 drives the pin high on a match while counting up (cnt_up = 1) and low on a tick at count 0x00. Code 100 is the mirror: low on an up-count match, high at 0x00. A down-count match does nothing. If a match and the zero event fall on the same tick, the match wins.
- R4: Code 101 drives the pin high on a match and low on a tick at 0xFF. Code 110 drives it low on a match and high on a tick at 0x00. If both events fall on the same tick, the match wins.
- R5: The pin is initialized by a clear pulse, or by a control write whose action code is 111. Such a write leaves the stored code unchanged. The level comes from the code stored before the edge: high for 001, 100 and 110, and low for the others. Initialization overrides any compare event in the same cycle.
- R6: In compare mode a value write is held. It is applied one edge after a tick with count 0x00. A later write replaces the held one. A write made in the same cycle as the zero tick stays held until the next zero tick.
- R7: In capture mode a value write takes effect on the next edge, unless a capture occurs in the same cycle, in which case the capture wins.
- R8: In capture mode the pin passes two synchronizer flops. Edge select 01 captures on rising edges, 10 on falling edges, 11 on both, and 00 never captures. The count is copied at the third clock edge after the pin changes. No capture happens in compare mode.
- R9: The flag is set by a capture, or by a compare-mode tick whose count equals the value. It is cleared by flag_clr. Setting wins over clearing.
- R10: irq equals flag AND mask, combinationally.
- R11: Without a tick, a clear pulse or a control write, the output pin holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt | input | 8 | Current counter value |
| cnt_up | input | 1 | Counter direction, 1 = counting up |
| cnt_tick | input | 1 | Counter holds a new value this cycle |
| cnt_clr | input | 1 | Counter clear pulse |
| ctl_we | input | 1 | Control field write strobe |
| ctl_im | input | 1 | Interrupt mask to write |
| ctl_cmp | input | 3 | Compare action code to write (111 = initialize) |
| ctl_mode | input | 1 | Channel mode to write, 1 = compare |
| ctl_cap | input | 2 | Capture edge select to write |
| val_we | input | 1 | Value register write strobe |
| val_din | input | 8 | Value to write |
| flag_clr | input | 1 | Clears the channel flag |
| cap_pin | input | 1 | Asynchronous capture input |
| val_q | output | 8 | Live channel value |
| out_pin | output | 1 | Compare output |
| flag | output | 1 | Sticky channel event flag |
| irq | output | 1 | Masked channel interrupt |

## Verification
A stale held value or a lost hold bit would show up on val_q at the first zero tick after a compare-mode write, or as a value that changes before that tick. A wrong stored action code or a wrong initialization level would show up on out_pin at the very next match, clear or initialize event, within one clock. A wrong synchronizer depth would make the capture land one cycle early or late, and that shows as an off-by-one cycle in val_q and flag. The bench therefore checks every output in every cycle against a model, and checks capture timing at the exact edge.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;

  typedef enum logic [2:0] {
    ACT_SET       = 3'd0,
    ACT_CLR       = 3'd1,
    ACT_TGL       = 3'd2,
    ACT_UPSET_ZLO = 3'd3,
    ACT_UPCLR_ZHI = 3'd4,
    ACT_SET_TLO   = 3'd5,
    ACT_CLR_ZHI   = 3'd6,
    ACT_INIT      = 3'd7
  } cmp_act_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } cap_edge_e;

  // Level the pin takes on initialization: opposite of what a match drives
  function automatic logic init_level(cmp_act_e act);
    return (act == ACT_CLR) || (act == ACT_UPCLR_ZHI) || (act == ACT_CLR_ZHI);
  endfunction

endpackage

// File: rtl/tmr_cc_edge.sv
module tmr_cc_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  localparam int LAST = SYNC_STAGES;

  // sh[0..SYNC_STAGES-1] form the synchronizer, sh[LAST] holds the previous level
  logic [LAST:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh[0] <= 1'b0;
    else        sh[0] <= pin;
  end

  for (genvar i = 1; i <= LAST; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh[i] <= 1'b0;
      else        sh[i] <= sh[i-1];
    end
  end

  assign rise = sh[LAST-1] & ~sh[LAST];
  assign fall = ~sh[LAST-1] & sh[LAST];
endmodule

// File: rtl/tmr_cc_value.sv
module tmr_cc_value #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_mode,
  input  logic         zero_tick,
  input  logic         cap_evt,
  input  logic [W-1:0] cnt,
  input  logic         wr,
  input  logic [W-1:0] din,
  output logic [W-1:0] val
);
  logic [W-1:0] hold_q;
  logic         hold_v;
  logic         wr_now, wr_held;

  assign wr_now  = wr & ~cmp_mode;
  assign wr_held = wr & cmp_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      hold_v <= 1'b0;
    end else if (wr_held) begin
      hold_q <= din;
      hold_v <= 1'b1;
    end else if (zero_tick) begin
      hold_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 val <= '0;
    else if (cap_evt)           val <= cnt;
    else if (wr_now)            val <= din;
    else if (zero_tick && hold_v) val <= hold_q;
  end
endmodule

// File: rtl/tmr_cc_out.sv
module tmr_cc_out #(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  tmr_cc_pkg::cmp_act_e act,
  input  logic                 active,
  input  logic                 init,
  input  logic                 match,
  input  logic                 up,
  input  logic [W-1:0]         cnt,
  output logic                 pin
);
  import tmr_cc_pkg::*;

  localparam logic [W-1:0] CNT_TOP = {W{1'b1}};

  logic at_zero, at_top, nxt;

  assign at_zero = (cnt == '0);
  assign at_top  = (cnt == CNT_TOP);

  always_comb begin
    nxt = pin;
    unique case (act)
      ACT_SET:       if (match) nxt = 1'b1;
      ACT_CLR:       if (match) nxt = 1'b0;
      ACT_TGL:       if (match) nxt = ~pin;
      ACT_UPSET_ZLO: if (match && up) nxt = 1'b1; else if (at_zero) nxt = 1'b0;
      ACT_UPCLR_ZHI: if (match && up) nxt = 1'b0; else if (at_zero) nxt = 1'b1;
      ACT_SET_TLO:   if (match) nxt = 1'b1; else if (at_top) nxt = 1'b0;
      ACT_CLR_ZHI:   if (match) nxt = 1'b0; else if (at_zero) nxt = 1'b1;
      default:       nxt = pin;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin <= 1'b0;
    else if (init)   pin <= init_level(act);
    else if (active) pin <= nxt;
  end
endmodule

// File: rtl/tmr_cc_channel.sv
module tmr_cc_channel #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic         cnt_up,
  input  logic         cnt_tick,
  input  logic         cnt_clr,
  input  logic         ctl_we,
  input  logic         ctl_im,
  input  logic [2:0]   ctl_cmp,
  input  logic         ctl_mode,
  input  logic [1:0]   ctl_cap,
  input  logic         val_we,
  input  logic [W-1:0] val_din,
  input  logic         flag_clr,
  input  logic         cap_pin,
  output logic [W-1:0] val_q,
  output logic         out_pin,
  output logic         flag,
  output logic         irq
);
  import tmr_cc_pkg::*;

  logic      im_q, mode_q;
  cmp_act_e  act_q;
  cap_edge_e edge_q;
  logic      rise, fall, cap_evt, zero_tick, match, init_req, cmp_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      im_q   <= 1'b1;
      mode_q <= 1'b0;
      act_q  <= ACT_SET;
      edge_q <= EDGE_NONE;
    end else if (ctl_we) begin
      im_q   <= ctl_im;
      mode_q <= ctl_mode;
      edge_q <= cap_edge_e'(ctl_cap);
      if (cmp_act_e'(ctl_cmp) != ACT_INIT) act_q <= cmp_act_e'(ctl_cmp);
    end
  end

  tmr_cc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (cap_pin),
    .rise (rise),
    .fall (fall)
  );

  assign cap_evt   = ~mode_q & ((edge_q[0] & rise) | (edge_q[1] & fall));
  assign zero_tick = cnt_tick & (cnt == '0);
  assign match     = (cnt == val_q);
  assign cmp_hit   = mode_q & cnt_tick & match;
  assign init_req  = cnt_clr | (ctl_we & (cmp_act_e'(ctl_cmp) == ACT_INIT));

  tmr_cc_value #(.W(W)) u_value (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_mode (mode_q),
    .zero_tick(zero_tick),
    .cap_evt  (cap_evt),
    .cnt      (cnt),
    .wr       (val_we),
    .din      (val_din),
    .val      (val_q)
  );

  tmr_cc_out #(.W(W)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act_q),
    .active(mode_q & cnt_tick),
    .init  (init_req),
    .match (match),
    .up    (cnt_up),
    .cnt   (cnt),
    .pin   (out_pin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   flag <= 1'b0;
    else if (cap_evt || cmp_hit)  flag <= 1'b1;
    else if (flag_clr)            flag <= 1'b0;
  end

  assign irq = flag & im_q;
endmodule

// File: rtl/tmr_cc_channel_chk.sv
module tmr_cc_channel_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cnt,
  input logic         cnt_tick,
  input logic         cnt_clr,
  input logic         ctl_we,
  input logic         val_we,
  input logic [W-1:0] val_din,
  input logic [W-1:0] val_q,
  input logic         out_pin,
  input logic         flag,
  input logic         mode_q,
  input logic [2:0]   act_q,
  input logic         cap_evt
);
  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_tick && !cnt_clr && !ctl_we) |=> $stable(out_pin)); // R11

  AST_INIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clr && (act_q == 3'd0 || act_q == 3'd2 || act_q == 3'd3 || act_q == 3'd5)) |=> !out_pin); // R5

  AST_INIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clr && (act_q == 3'd1 || act_q == 3'd4 || act_q == 3'd6)) |=> out_pin); // R5

  AST_HELD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !(cnt_tick && cnt == '0)) |=> $stable(val_q)); // R6

  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && val_we && !cap_evt) |=> (val_q == $past(val_din))); // R7

  AST_FLAG_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> flag); // R9
endmodule

bind tmr_cc_channel tmr_cc_channel_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cnt     (cnt),
  .cnt_tick(cnt_tick),
  .cnt_clr (cnt_clr),
  .ctl_we  (ctl_we),
  .val_we  (val_we),
  .val_din (val_din),
  .val_q   (val_q),
  .out_pin (out_pin),
  .flag    (flag),
  .mode_q  (mode_q),
  .act_q   (act_q),
  .cap_evt (cap_evt)
);

// File: tb/tmr_cc_channel_test.sv
module tmr_cc_channel_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cnt = '0;
  logic       cnt_up = 1'b0, cnt_tick = 1'b0, cnt_clr = 1'b0;
  logic       ctl_we = 1'b0, ctl_im = 1'b0, ctl_mode = 1'b0;
  logic [2:0] ctl_cmp = '0;
  logic [1:0] ctl_cap = '0;
  logic       val_we = 1'b0, flag_clr = 1'b0, cap_pin = 1'b0;
  logic [7:0] val_din = '0;
  logic [7:0] val_q;
  logic       out_pin, flag, irq;

  int tests = 0, fails = 0, cycles = 0;
  bit use_model = 1'b0;

  // reference state
  logic       m_im, m_mode, m_out, m_flag, m_hv;
  logic [2:0] m_act;
  logic [7:0] m_val, m_hold;

  always #5 clk = ~clk;

  tmr_cc_channel uut (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_up(cnt_up), .cnt_tick(cnt_tick),
    .cnt_clr(cnt_clr), .ctl_we(ctl_we), .ctl_im(ctl_im), .ctl_cmp(ctl_cmp),
    .ctl_mode(ctl_mode), .ctl_cap(ctl_cap), .val_we(val_we), .val_din(val_din),
    .flag_clr(flag_clr), .cap_pin(cap_pin), .val_q(val_q), .out_pin(out_pin),
    .flag(flag), .irq(irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic lvl_init(input logic [2:0] a);
    return (a == 3'd1) || (a == 3'd4) || (a == 3'd6);
  endfunction

  function automatic logic act_next(input logic [2:0] a, input logic o, input logic m,
                                    input logic up, input logic [7:0] c);
    case (a)
      3'd0: return m ? 1'b1 : o;
      3'd1: return m ? 1'b0 : o;
      3'd2: return m ? ~o : o;
      3'd3: return (m && up) ? 1'b1 : (c == 8'h00) ? 1'b0 : o;
      3'd4: return (m && up) ? 1'b0 : (c == 8'h00) ? 1'b1 : o;
      3'd5: return m ? 1'b1 : (c == 8'hFF) ? 1'b0 : o;
      3'd6: return m ? 1'b0 : (c == 8'h00) ? 1'b1 : o;
      default: return o;
    endcase
  endfunction

  function automatic string out_req(input logic [2:0] a, input bit init, input bit quiet);
    if (init)  return "R5";
    if (quiet) return "R11";
    if (a <= 3'd2) return "R2";
    if (a <= 3'd4) return "R3";
    return "R4";
  endfunction

  task automatic model_reset();
    m_im = 1'b1; m_mode = 1'b0; m_act = 3'd0; m_out = 1'b0; m_flag = 1'b0;
    m_val = '0; m_hold = '0; m_hv = 1'b0;
  endtask

  // one clock; model advances from the inputs present before the edge (no capture in model)
  task automatic step();
    logic n_out, n_flag, n_hv, init, zt, m;
    logic [7:0] n_val, n_hold;
    string oreq, vreq;
    init = cnt_clr || (ctl_we && ctl_cmp == 3'd7);
    zt   = cnt_tick && (cnt == 8'h00);
    m    = (cnt == m_val);
    n_out = m_out;
    if (init) n_out = lvl_init(m_act);
    else if (m_mode && cnt_tick) n_out = act_next(m_act, m_out, m, cnt_up, cnt);
    oreq = out_req(m_act, init, !cnt_tick && !cnt_clr && !ctl_we);
    vreq = m_mode ? "R6" : "R7";
    n_val = m_val; n_hold = m_hold; n_hv = m_hv;
    if (!m_mode && val_we) n_val = val_din;
    else if (zt && m_hv) n_val = m_hold;
    if (m_mode && val_we) begin n_hold = val_din; n_hv = 1'b1; end
    else if (zt) n_hv = 1'b0;
    n_flag = (m_mode && cnt_tick && m) ? 1'b1 : (flag_clr ? 1'b0 : m_flag);
    @(posedge clk);
    @(negedge clk);
    if (use_model) begin
      if (ctl_we) begin
        m_im = ctl_im; m_mode = ctl_mode;
        if (ctl_cmp != 3'd7) m_act = ctl_cmp;
      end
      m_out = n_out; m_val = n_val; m_hold = n_hold; m_hv = n_hv; m_flag = n_flag;
      chk(out_pin == m_out, oreq, out_pin, m_out);
      chk(val_q == m_val, vreq, val_q, m_val);
      chk(flag == m_flag, "R9", flag, m_flag);
      chk(irq == (m_flag & m_im), "R10", irq, m_flag & m_im);
    end
  endtask

  function automatic logic [7:0] pickv();
    case ($urandom % 6)
      0: return 8'h00;
      1: return 8'h01;
      2: return 8'h02;
      3: return 8'h03;
      4: return 8'hFF;
      default: return 8'($urandom);
    endcase
  endfunction

  task automatic idle_inputs();
    cnt_tick = 0; cnt_clr = 0; ctl_we = 0; val_we = 0; flag_clr = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; idle_inputs(); cap_pin = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  task automatic ctl(input logic im, input logic [2:0] a, input logic md, input logic [1:0] cp);
    ctl_we = 1; ctl_im = im; ctl_cmp = a; ctl_mode = md; ctl_cap = cp;
    step();
    ctl_we = 0;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk(val_q == 8'h00, "R1", val_q, 0);
    chk(out_pin == 1'b0, "R1", out_pin, 0);
    chk(flag == 1'b0, "R1", flag, 0);
    chk(irq == 1'b0, "R1", irq, 0);

    // random compare-mode traffic against the model
    use_model = 1;
    ctl(1'b1, 3'd0, 1'b1, 2'd0);
    for (int i = 0; i < 4000; i++) begin
      cnt      = pickv();
      cnt_up   = 1'($urandom);
      cnt_tick = ($urandom % 10) < 6;
      cnt_clr  = ($urandom % 40) == 0;
      ctl_we   = ($urandom % 12) == 0;
      ctl_im   = 1'($urandom);
      ctl_cmp  = 3'($urandom);
      ctl_mode = ($urandom % 10) != 0;
      ctl_cap  = 2'($urandom);
      val_we   = ($urandom % 10) == 0;
      val_din  = pickv();
      flag_clr = ($urandom % 8) == 0;
      step();
    end
    idle_inputs();
    use_model = 0;

    // directed capture cases
    do_reset();
    ctl(1'b1, 3'd0, 1'b0, 2'd1);
    cnt = 8'h5A; cap_pin = 1;
    step(); step();
    chk(val_q == 8'h00, "R8 early", val_q, 0);
    step();
    chk(val_q == 8'h5A, "R8 rise", val_q, 8'h5A);
    chk(flag == 1'b1, "R9 capture", flag, 1);
    chk(irq == 1'b1, "R10", irq, 1);
    flag_clr = 1; step(); flag_clr = 0;
    chk(flag == 1'b0, "R9 clear", flag, 0);
    cnt = 8'h11; cap_pin = 0;
    repeat (4) step();
    chk(val_q == 8'h5A, "R8 fall ignored", val_q, 8'h5A);
    chk(flag == 1'b0, "R8 no flag", flag, 0);
    ctl(1'b1, 3'd0, 1'b0, 2'd2);
    cap_pin = 1; repeat (4) step();
    chk(val_q == 8'h5A, "R8 rise ignored", val_q, 8'h5A);
    cnt = 8'h22; cap_pin = 0; repeat (3) step();
    chk(val_q == 8'h22, "R8 fall", val_q, 8'h22);
    ctl(1'b1, 3'd0, 1'b0, 2'd3);
    cnt = 8'h33; cap_pin = 1; repeat (3) step();
    chk(val_q == 8'h33, "R8 both rise", val_q, 8'h33);
    cnt = 8'h44; cap_pin = 0; repeat (3) step();
    chk(val_q == 8'h44, "R8 both fall", val_q, 8'h44);
    ctl(1'b1, 3'd0, 1'b0, 2'd0);
    cnt = 8'h55; cap_pin = 1; repeat (4) step();
    chk(val_q == 8'h44, "R8 none", val_q, 8'h44);
    ctl(1'b1, 3'd0, 1'b1, 2'd3);
    cnt = 8'h66; cap_pin = 0; repeat (4) step();
    chk(val_q == 8'h44, "R8 compare mode", val_q, 8'h44);
    // R10 mask
    chk(flag == 1'b1, "R9 sticky", flag, 1);
    ctl(1'b0, 3'd0, 1'b1, 2'd3);
    chk(irq == 1'b0, "R10 masked", irq, 0);

    // R5 initialize keeps stored code
    ctl(1'b1, 3'd1, 1'b1, 2'd0);
    ctl(1'b1, 3'd7, 1'b1, 2'd0);
    chk(out_pin == 1'b1, "R5 init level", out_pin, 1);
    cnt = 8'h44; cnt_tick = 1; step(); cnt_tick = 0;
    chk(out_pin == 1'b0, "R5 code kept", out_pin, 0);

    // R6 held write
    val_we = 1; val_din = 8'h77; step(); val_we = 0;
    cnt = 8'h05; cnt_tick = 1; step();
    chk(val_q == 8'h44, "R6 held", val_q, 8'h44);
    cnt = 8'h00; step(); cnt_tick = 0;
    chk(val_q == 8'h77, "R6 applied", val_q, 8'h77);

    // R7 direct write
    ctl(1'b1, 3'd0, 1'b0, 2'd0);
    val_we = 1; val_din = 8'h99; step(); val_we = 0;
    chk(val_q == 8'h99, "R7 direct", val_q, 8'h99);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule